// File: doc/BRIEF.md
# Per-Core Task Vulnerability Tracker

This block measures how prone each core of a processor cluster is to timing-errant instructions while it runs a given kind of work. Every core feeds the block five signals: a one-cycle pulse for each retired instruction, a one-cycle pulse for each instruction its error sensor flagged, a strobe when a task begins, a strobe when it ends, and the type code of the task. At the end strobe the lane of that core divides its errant count by its instruction count. The quotient is an unsigned Q0.16 fraction, and a smaller value means a more reliable pairing.

The new fraction is then averaged into a table that has one entry for each pairing of task type and core. A task scheduler reads the table through a combinational lookup port, so a result is available in the same cycle. It uses the values to steer tasks away from cores that behave badly on them. All cores measure in parallel. Each lane runs its own sequential divider. A round-robin arbiter lets exactly one finished lane write the table per cycle, and the other finished lanes keep their results until they are granted.

The expected usage is that a core finishes a task only after its previous result has reached the table. That takes about `RATIO_W + NUM_CORES + 3` cycles.

Top module: `task_vuln_tracker`

## Requirements
- R1: After reset every table entry reads 0. The read port returns the entry at (`rd_type`, `rd_core`) combinationally, in the same cycle the address is applied.
- R2: For a task with I executed and E errant instructions (I > 0), the measured ratio is floor(E * 65536 / I) when E < I. When E >= I the ratio is 0xFFFF.
- R3: On a write the entry becomes floor((stored + ratio) / 2).
- R4: A `task_start` strobe clears both counters of its core. Pulses seen before the strobe do not count. The task type is sampled in the start cycle, and later changes of the type input do not affect that task.
- R5: A task that retires zero instructions leaves its table entry unchanged, whatever its errant count.
- R6: When several cores finish together, every result is written exactly once to its own entry. At most one write occurs per cycle, with round-robin grants. A result that has not been granted stays pending.
- R7: The instruction and errant counters stop at 2^CNT_W - 1 and do not wrap. With the default width, 66000 instructions count as 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_ret | input | NUM_CORES | Per-core retired-instruction pulse |
| instr_err | input | NUM_CORES | Per-core errant-instruction pulse |
| task_start | input | NUM_CORES | Per-core task begin strobe |
| task_end | input | NUM_CORES | Per-core task finish strobe |
| task_type | input | NUM_CORES*TYPE_W | Per-core task type code, core c in bits [c*TYPE_W +: TYPE_W] |
| rd_core | input | CORE_W | Lookup core index |
| rd_type | input | TYPE_W | Lookup task type |
| rd_ratio | output | RATIO_W | Stored Q0.16 vulnerability value |

## Verification
The bench targets a task whose errant count equals its instruction count. A divider that skipped the saturating path there would return a wrapped or zero quotient instead of 0xFFFF. A task with errant pulses but no instructions follows. It would corrupt the entry if the zero-divisor case were not filtered. Stray pulses before a start strobe and a type change in the middle of a task check that clearing and type capture happen at the strobe; a design that got them wrong would inflate the ratio or write the wrong row. Sixteen cores finishing in the same cycle would expose a lost or doubled write. A run of more than 65535 instructions would show a wrapping counter as a 0xFFFF ratio where 16384 is expected.

// File: rtl/vt_pkg.sv
package vt_pkg;

  typedef enum logic [1:0] {
    LANE_IDLE = 2'd0,
    LANE_DIV  = 2'd1,
    LANE_PEND = 2'd2
  } lane_st_e;

endpackage

// File: rtl/vt_seq_divider.sv
// Restoring divider producing a Q_W-bit fraction num/den, requires num < den.
module vt_seq_divider #(
  parameter int NUM_W = 16,
  parameter int Q_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [NUM_W-1:0] den,
  output logic             done,
  output logic [Q_W-1:0]   quo
);

  localparam int CW = $clog2(Q_W + 1);

  logic [NUM_W:0]   rem_q, rem_d;
  logic [NUM_W-1:0] den_q;
  logic [Q_W-1:0]   quo_q, quo_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [NUM_W:0]   shifted;
  logic [NUM_W:0]   den_ext;

  assign den_ext = {1'b0, den_q};
  assign shifted = {rem_q[NUM_W-1:0], 1'b0};

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start) begin
      rem_d  = {1'b0, num};
      quo_d  = '0;
      cnt_d  = CW'(Q_W);
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (shifted >= den_ext) begin
        rem_d = shifted - den_ext;
        quo_d = {quo_q[Q_W-2:0], 1'b1};
      end else begin
        rem_d = shifted;
        quo_d = {quo_q[Q_W-2:0], 1'b0};
      end
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
      if (start) den_q <= den;
    end
  end

  assign done = done_q;
  assign quo  = quo_q;

endmodule

// File: rtl/vt_core_lane.sv
// One lane per core: saturating counters, ratio computation, pending result.
module vt_core_lane
  import vt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int RATIO_W = 16,
  parameter int TYPE_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_pulse,
  input  logic              err_pulse,
  input  logic              start,
  input  logic              finish,
  input  logic [TYPE_W-1:0] type_in,
  input  logic              grant,
  output logic              req,
  output logic [RATIO_W-1:0] ratio,
  output logic [TYPE_W-1:0] res_type
);

  logic [CNT_W-1:0]   instr_cnt_q, instr_base, instr_nxt;
  logic [CNT_W-1:0]   err_cnt_q, err_base, err_nxt;
  logic [TYPE_W-1:0]  type_q;
  logic [TYPE_W-1:0]  res_type_q;
  logic [RATIO_W-1:0] ratio_q, ratio_d;
  lane_st_e           st_q, st_d;
  logic               accept;
  logic               div_start;
  logic               div_done;
  logic [RATIO_W-1:0] div_quo;

  // Saturating counters; a start strobe restarts them from zero.
  always_comb begin
    instr_base = start ? '0 : instr_cnt_q;
    err_base   = start ? '0 : err_cnt_q;
    instr_nxt  = (&instr_base) ? instr_base : instr_base + CNT_W'(instr_pulse);
    err_nxt    = (&err_base)   ? err_base   : err_base   + CNT_W'(err_pulse);
  end

  assign accept    = (st_q == LANE_IDLE) && finish && (instr_nxt != '0);
  assign div_start = accept && (err_nxt < instr_nxt);

  always_comb begin
    st_d    = st_q;
    ratio_d = ratio_q;
    case (st_q)
      LANE_IDLE: begin
        if (accept) begin
          if (err_nxt >= instr_nxt) begin
            st_d    = LANE_PEND;
            ratio_d = '1;
          end else begin
            st_d = LANE_DIV;
          end
        end
      end
      LANE_DIV: begin
        if (div_done) begin
          st_d    = LANE_PEND;
          ratio_d = div_quo;
        end
      end
      LANE_PEND: begin
        if (grant) st_d = LANE_IDLE;
      end
      default: st_d = LANE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_cnt_q <= '0;
      err_cnt_q   <= '0;
      type_q      <= '0;
      res_type_q  <= '0;
      ratio_q     <= '0;
      st_q        <= LANE_IDLE;
    end else begin
      if (start || instr_pulse) instr_cnt_q <= instr_nxt;
      if (start || err_pulse)   err_cnt_q   <= err_nxt;
      if (start)                type_q      <= type_in;
      if (accept)               res_type_q  <= type_q;
      ratio_q <= ratio_d;
      st_q    <= st_d;
    end
  end

  vt_seq_divider #(
    .NUM_W (CNT_W),
    .Q_W   (RATIO_W)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (err_nxt),
    .den   (instr_nxt),
    .done  (div_done),
    .quo   (div_quo)
  );

  assign req      = (st_q == LANE_PEND);
  assign ratio    = ratio_q;
  assign res_type = res_type_q;

endmodule

// File: rtl/vt_rr_arbiter.sv
module vt_rr_arbiter #(
  parameter int N = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  output logic [N-1:0]         grant,
  output logic [$clog2(N)-1:0] gidx
);

  localparam int PW = $clog2(N);

  logic [PW-1:0] ptr_q, ptr_d;
  logic          found;

  always_comb begin
    grant = '0;
    gidx  = '0;
    found = 1'b0;
    for (int off = 0; off < N; off++) begin
      int idx;
      idx = int'(ptr_q) + off;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx]) begin
        found      = 1'b1;
        grant[idx] = 1'b1;
        gidx       = PW'(idx);
      end
    end
    ptr_d = ptr_q;
    if (found) ptr_d = (gidx == PW'(N - 1)) ? '0 : gidx + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

endmodule

// File: rtl/vt_vuln_table.sv
module vt_vuln_table #(
  parameter int NC      = 16,
  parameter int NT      = 4,
  parameter int RATIO_W = 16,
  parameter int CORE_W  = 4,
  parameter int TYPE_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CORE_W-1:0]  wr_core,
  input  logic [TYPE_W-1:0]  wr_type,
  input  logic [RATIO_W-1:0] wr_ratio,
  input  logic [CORE_W-1:0]  rd_core,
  input  logic [TYPE_W-1:0]  rd_type,
  output logic [RATIO_W-1:0] rd_ratio
);

  logic [RATIO_W-1:0] ent [NT][NC];
  logic [RATIO_W-1:0] old_val;
  logic [RATIO_W:0]   sum;
  logic [RATIO_W-1:0] avg;

  always_comb begin
    old_val = '0;
    for (int t = 0; t < NT; t++)
      for (int c = 0; c < NC; c++)
        if (wr_type == TYPE_W'(t) && wr_core == CORE_W'(c)) old_val = ent[t][c];
    sum = {1'b0, old_val} + {1'b0, wr_ratio};
    avg = sum[RATIO_W:1];
  end

  for (genvar t = 0; t < NT; t++) begin : g_type
    for (genvar c = 0; c < NC; c++) begin : g_core
      logic hit;
      assign hit = wr_en && (wr_type == TYPE_W'(t)) && (wr_core == CORE_W'(c));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   ent[t][c] <= '0;
        else if (hit) ent[t][c] <= avg;
      end
    end
  end

  always_comb begin
    rd_ratio = '0;
    for (int t = 0; t < NT; t++)
      for (int c = 0; c < NC; c++)
        if (rd_type == TYPE_W'(t) && rd_core == CORE_W'(c)) rd_ratio = ent[t][c];
  end

endmodule

// File: rtl/task_vuln_tracker.sv
module task_vuln_tracker #(
  parameter int NUM_CORES = 16,
  parameter int NUM_TYPES = 4,
  parameter int CNT_W     = 16,
  parameter int RATIO_W   = 16,
  parameter int CORE_W    = $clog2(NUM_CORES),
  parameter int TYPE_W    = $clog2(NUM_TYPES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CORES-1:0]        instr_ret,
  input  logic [NUM_CORES-1:0]        instr_err,
  input  logic [NUM_CORES-1:0]        task_start,
  input  logic [NUM_CORES-1:0]        task_end,
  input  logic [NUM_CORES*TYPE_W-1:0] task_type,
  input  logic [CORE_W-1:0]           rd_core,
  input  logic [TYPE_W-1:0]           rd_type,
  output logic [RATIO_W-1:0]          rd_ratio
);

  logic [1:0]           rst_sync_q;
  logic                 rst_sync_n;
  logic [NUM_CORES-1:0] lane_req;
  logic [NUM_CORES-1:0] lane_gnt;
  logic [RATIO_W-1:0]   lane_ratio [NUM_CORES];
  logic [TYPE_W-1:0]    lane_type  [NUM_CORES];
  logic [CORE_W-1:0]    gnt_idx;
  logic                 wr_en;
  logic [RATIO_W-1:0]   wr_ratio;
  logic [TYPE_W-1:0]    wr_type;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_lane
    vt_core_lane #(
      .CNT_W   (CNT_W),
      .RATIO_W (RATIO_W),
      .TYPE_W  (TYPE_W)
    ) u_lane (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .instr_pulse (instr_ret[c]),
      .err_pulse   (instr_err[c]),
      .start       (task_start[c]),
      .finish      (task_end[c]),
      .type_in     (task_type[c*TYPE_W +: TYPE_W]),
      .grant       (lane_gnt[c]),
      .req         (lane_req[c]),
      .ratio       (lane_ratio[c]),
      .res_type    (lane_type[c])
    );
  end

  vt_rr_arbiter #(
    .N (NUM_CORES)
  ) u_arb (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .req   (lane_req),
    .grant (lane_gnt),
    .gidx  (gnt_idx)
  );

  always_comb begin
    wr_en    = |lane_gnt;
    wr_ratio = '0;
    wr_type  = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (lane_gnt[c]) begin
        wr_ratio = lane_ratio[c];
        wr_type  = lane_type[c];
      end
    end
  end

  vt_vuln_table #(
    .NC      (NUM_CORES),
    .NT      (NUM_TYPES),
    .RATIO_W (RATIO_W),
    .CORE_W  (CORE_W),
    .TYPE_W  (TYPE_W)
  ) u_tab (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_core  (gnt_idx),
    .wr_type  (wr_type),
    .wr_ratio (wr_ratio),
    .rd_core  (rd_core),
    .rd_type  (rd_type),
    .rd_ratio (rd_ratio)
  );

endmodule

// File: rtl/vt_tracker_chk.sv
module vt_tracker_chk #(
  parameter int NUM_CORES = 16,
  parameter int RATIO_W   = 16,
  parameter int CORE_W    = 4,
  parameter int TYPE_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CORES-1:0] req,
  input logic [NUM_CORES-1:0] grant,
  input logic                 wr_en,
  input logic [CORE_W-1:0]    rd_core,
  input logic [TYPE_W-1:0]    rd_type,
  input logic [RATIO_W-1:0]   rd_ratio
);

  // R6: one table write per cycle
  assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R6: grants go only to lanes holding a result
  assert_grant_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~req) == '0));

  // R6: a result not granted stays pending
  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req & ~grant)) |=> (((($past(req) & ~$past(grant))) & ~req) == '0));

  // R6: a granted lane drops its request in the next cycle
  assert_req_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |=> (($past(grant) & req) == '0));

  // R1: with no write and a fixed address the lookup does not change
  assert_read_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_core) && $stable(rd_type) && !$past(wr_en)) |-> $stable(rd_ratio));

endmodule

bind task_vuln_tracker vt_tracker_chk #(
  .NUM_CORES (NUM_CORES),
  .RATIO_W   (RATIO_W),
  .CORE_W    (CORE_W),
  .TYPE_W    (TYPE_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .req      (lane_req),
  .grant    (lane_gnt),
  .wr_en    (wr_en),
  .rd_core  (rd_core),
  .rd_type  (rd_type),
  .rd_ratio (rd_ratio)
);

// File: tb/sim_task_vuln_tracker.sv
`timescale 1ns/1ps
module sim_task_vuln_tracker;

  localparam int NC = 16;
  localparam int NT = 4;

  logic          clk;
  logic          rst_n;
  logic [NC-1:0] ins, er, st, en;
  logic [NC*2-1:0] ty_flat;
  logic [3:0]    rd_core;
  logic [1:0]    rd_type;
  logic [15:0]   rd_ratio;

  int n_checks = 0;
  int n_fail   = 0;
  int tab [NC][NT];

  typedef struct {
    int    core;
    int    typ;
    int    expv;
    string tag;
  } sb_item_t;
  sb_item_t sbq[$];

  task_vuln_tracker u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_ret  (ins),
    .instr_err  (er),
    .task_start (st),
    .task_end   (en),
    .task_type  (ty_flat),
    .rd_core    (rd_core),
    .rd_type    (rd_type),
    .rd_ratio   (rd_ratio)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    finish_run();
  end

  // Model of R2/R3/R5/R7: ratio, averaging, zero filter, saturation
  task automatic model(int c, int t, int ni, int ne, string tag);
    longint r;
    int i_s, e_s;
    i_s = (ni > 65535) ? 65535 : ni;
    e_s = (ne > 65535) ? 65535 : ne;
    if (i_s != 0) begin
      if (e_s >= i_s) r = 65535;
      else            r = (longint'(e_s) << 16) / i_s;
      tab[c][t] = int'((longint'(tab[c][t]) + r) / 2);
    end
    sbq.push_back('{core: c, typ: t, expv: tab[c][t], tag: tag});
  endtask

  // Driver: one task on one core; type input is scrambled after start (R4)
  task automatic run_one(int c, int t, int ni, int ne, string tag);
    int len;
    len = (ni > ne) ? ni : ne;
    @(negedge clk);
    st[c] = 1'b1;
    ty_flat[c*2 +: 2] = t[1:0];
    @(negedge clk);
    st[c] = 1'b0;
    ty_flat[c*2 +: 2] = ~t[1:0];
    for (int i = 0; i < len; i++) begin
      ins[c] = (i < ni);
      er[c]  = (i < ne);
      @(negedge clk);
    end
    ins[c] = 1'b0;
    er[c]  = 1'b0;
    en[c]  = 1'b1;
    @(negedge clk);
    en[c]  = 1'b0;
    model(c, t, ni, ne, tag);
  endtask

  // Monitor: pop expected entries and compare against the lookup port
  task automatic drain();
    while (sbq.size() > 0) begin
      sb_item_t it;
      it = sbq.pop_front();
      @(negedge clk);
      rd_core = it.core[3:0];
      rd_type = it.typ[1:0];
      #1;
      n_checks++;
      if (rd_ratio !== it.expv[15:0]) begin
        n_fail++;
        $display("FAIL %s core %0d type %0d: actual %0d expected %0d",
                 it.tag, it.core, it.typ, rd_ratio, it.expv);
      end
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    ins = '0; er = '0; st = '0; en = '0; ty_flat = '0;
    rd_core = '0; rd_type = '0;
    for (int c = 0; c < NC; c++)
      for (int t = 0; t < NT; t++) tab[c][t] = 0;
    settle(4);
    rst_n = 1'b1;
    settle(5);

    // R1: reset contents, same-cycle lookup
    sbq.push_back('{core: 0,  typ: 0, expv: 0, tag: "R1"});
    sbq.push_back('{core: 15, typ: 3, expv: 0, tag: "R1"});
    sbq.push_back('{core: 7,  typ: 2, expv: 0, tag: "R1"});
    sbq.push_back('{core: 9,  typ: 1, expv: 0, tag: "R1"});
    drain();

    // R2: plain ratio 25/100 -> 16384, entry 8192
    run_one(0, 1, 100, 25, "R2");
    settle(50); drain();
    // R3: second task folds in by averaging -> 12288
    run_one(0, 1, 100, 25, "R3");
    settle(50); drain();
    // R2: non-exact quotient 1/7 truncated
    run_one(6, 3, 7, 1, "R2");
    settle(50); drain();
    // R2: errant equals executed -> 0xFFFF, entry 32767
    run_one(4, 0, 10, 10, "R2");
    settle(50); drain();

    // R5: value first, then zero-instruction task leaves it unchanged
    run_one(3, 2, 40, 8, "R5");
    settle(50); drain();
    run_one(3, 2, 0, 5, "R5");
    settle(50); drain();

    // R4: stray pulses before start must be cleared
    for (int i = 0; i < 9; i++) begin
      @(negedge clk); ins[5] = 1'b1; er[5] = 1'b1;
    end
    @(negedge clk); ins[5] = 1'b0; er[5] = 1'b0;
    run_one(5, 1, 50, 5, "R4");
    settle(50); drain();
    // R4: the scrambled type row must still be zero
    sbq.push_back('{core: 5, typ: 2, expv: tab[5][2], tag: "R4"});
    drain();

    // R6: all cores finish in the same cycle
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      st[c] = 1'b1;
      ty_flat[c*2 +: 2] = 2'(c % NT);
    end
    @(negedge clk);
    st = '0;
    for (int k = 0; k < 80; k++) begin
      for (int c = 0; c < NC; c++) begin
        ins[c] = (k < 30 + 3*c);
        er[c]  = (k < c);
      end
      @(negedge clk);
    end
    ins = '0; er = '0; en = '1;
    @(negedge clk);
    en = '0;
    for (int c = 0; c < NC; c++) model(c, c % NT, 30 + 3*c, c, "R6");
    settle(80); drain();

    // R7: 66000 instructions saturate at 65535 -> ratio 16384, entry 8192
    run_one(7, 2, 66000, 16384, "R7");
    settle(50); drain();

    finish_run();
  end

endmodule